// File: doc/BRIEF.md
# Block-Lock Write Protection Controller

This block sits between the serial command front end of a small nonvolatile byte memory and its write-timing engine. For each requested nonvolatile write it decides whether the write is granted or refused. The request may target the memory array or the status register. The block holds the write-enable latch and the two region-protect bits. It also holds the pin-lock enable bit, which arms the external write-protect pin. These values are presented as a status byte that the front end can shift out.

The front end supplies one-cycle command strobes and the target address. For status writes it also supplies the data byte, and it follows chip select throughout. The timing engine reports an in-progress write through a busy flag. An array write is decided in the cycle after its strobe. A status write is held pending until chip select rises, and it is cancelled if the protect pin drops first while the lock enable is set. The end of every completed write cycle clears the write-enable latch.

Top module: `wpc_ctrl`

## Requirements
- R1: After reset, the write-enable latch, both region bits and the pin-lock enable are 0, and every grant and deny output is low.
- R2: A set-enable strobe sets the write-enable latch when busy is low. A clear-enable strobe clears it, and clear wins when both strobes arrive together. A set-enable strobe while busy is high is ignored.
- R3: A falling edge of busy clears the write-enable latch. The cleared value is visible one cycle after the first cycle with busy low.
- R4: An array request is answered one cycle later with exactly one of two outputs. `arr_grant_o` pulses when the latch is set, busy is low and the address is unprotected. Otherwise `arr_deny_o` pulses.
- R5: The region bits (status bits 3:2) select the protected array range. 00 protects nothing. 01 protects 0x1800–0x1FFF. 10 protects 0x1000–0x1FFF. 11 protects the whole array.
- R6: Array or status requests that arrive while busy is high are denied.
- R7: A status request is denied at once when the latch is clear, or when the lock enable is 1 and `wp_i` is low. When the lock enable is 0, `wp_i` has no effect.
- R8: An accepted status request stays pending until `cs_n_i` is sampled high. At that edge `sr_grant_o` pulses, and the new region and lock bits appear in the same cycle.
- R9: If `wp_i` is sampled low while a status write is pending, `cs_n_i` is still low and the lock enable is 1, the write is cancelled. `sr_deny_o` pulses and the stored bits stay unchanged.
- R10: The status byte is bit 0 = busy, bit 1 = write-enable latch, bits 3:2 = region bits, bit 7 = lock enable, and bits 6:4 read 0. Data bits 6:4, 1 and 0 of a status write are ignored.
- R11: A denied array write to a protected address starts no grant and leaves the write-enable latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Chip select level, low = selected |
| wp_i | input | 1 | Write-protect pin level, low = protect |
| busy_i | input | 1 | Write cycle in progress from timing engine |
| set_wel_i | input | 1 | Set-enable command strobe |
| clr_wel_i | input | 1 | Clear-enable command strobe |
| arr_req_i | input | 1 | Array write request strobe |
| arr_addr_i | input | ADDR_W | Array write target address |
| sr_req_i | input | 1 | Status write request strobe |
| sr_data_i | input | 8 | Status write data byte |
| arr_grant_o | output | 1 | Array write granted (pulse) |
| arr_deny_o | output | 1 | Array write refused (pulse) |
| sr_grant_o | output | 1 | Status write committed (pulse) |
| sr_deny_o | output | 1 | Status write refused or cancelled (pulse) |
| status_o | output | 8 | Status byte |

## Verification
Array requests are sent to the addresses on each side of each range boundary, 0x17FF/0x1800 and 0x0FFF/0x1000, under every region setting. A bad decode therefore shows up as a swapped grant at one exact address. Status writes are tried with the pin high, with the pin low and the lock armed, and with the pin low and the lock disarmed. Together these cases show whether the pin test is gated by the stored enable. A pin drop between request and chip-select rise separates cancellation from commit. Busy pulses and overlapping set/clear strobes show the latch priorities.

// File: rtl/wpc_pkg.sv
// Shared types for the write protection controller.
package wpc_pkg;
    typedef enum logic [1:0] {
        BP_NONE    = 2'b00,
        BP_QUARTER = 2'b01,
        BP_HALF    = 2'b10,
        BP_ALL     = 2'b11
    } bp_e;
endpackage

// File: rtl/wpc_region.sv
// Region decode: flags an address as protected from its two top bits.
// Assumes the array is split into four equal quarters by those bits.
module wpc_region
    import wpc_pkg::*;
(
    input  bp_e        bp,
    input  logic [1:0] addr_msb,
    output logic       prot
);
    // Compare the address quarter against the selected region.
    always_comb begin
        case (bp)
            BP_NONE:    prot = 1'b0;
            BP_QUARTER: prot = &addr_msb;
            BP_HALF:    prot = addr_msb[1];
            default:    prot = 1'b1;
        endcase
    end
endmodule

// File: rtl/wpc_latch.sv
// Write-enable latch. Clear and end-of-write win over set.
// Assumes the strobes are one-cycle pulses from the front end.
module wpc_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic busy_i,
    input  logic wr_done_i,
    output logic wel_o
);
    // Latch update with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wel_o <= 1'b0;
        else if (clr_i || wr_done_i)
            wel_o <= 1'b0;
        else if (set_i && !busy_i)
            wel_o <= 1'b1;
    end
endmodule

// File: rtl/wpc_sreg.sv
// Status register writer. It holds the region and lock bits, accepts
// or refuses a status write request, and keeps an accepted request
// pending until chip select rises. A protect-pin drop while pending
// cancels the write. Assumes a request arrives with chip select low.
module wpc_sreg
    import wpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic [2:0] data_i,
    input  logic       wel_i,
    input  logic       busy_i,
    input  logic       wp_i,
    input  logic       cs_n_i,
    output bp_e        bp_o,
    output logic       lock_o,
    output logic       grant_o,
    output logic       deny_o
);
    logic       pend_q;
    logic [2:0] pdata_q;
    logic       pin_blocks;

    assign pin_blocks = lock_o && !wp_i;

    // Request check, pending hold, commit and cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_o    <= BP_NONE;
            lock_o  <= 1'b0;
            pend_q  <= 1'b0;
            pdata_q <= 3'b000;
            grant_o <= 1'b0;
            deny_o  <= 1'b0;
        end else begin
            grant_o <= 1'b0;
            deny_o  <= 1'b0;
            if (req_i) begin
                if (!wel_i || busy_i || pin_blocks) begin
                    deny_o <= 1'b1;
                end else begin
                    pend_q  <= 1'b1;
                    pdata_q <= data_i;
                end
            end else if (pend_q) begin
                if (cs_n_i) begin
                    grant_o <= 1'b1;
                    bp_o    <= bp_e'(pdata_q[1:0]);
                    lock_o  <= pdata_q[2];
                    pend_q  <= 1'b0;
                end else if (pin_blocks) begin
                    deny_o <= 1'b1;
                    pend_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/wpc_ctrl.sv
// Top of the write protection controller. It decides array writes
// against the latch, busy and region, and hands status writes to the
// status writer. Assumes busy comes from a self-timed write engine.
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              wp_i,
    input  logic              busy_i,
    input  logic              set_wel_i,
    input  logic              clr_wel_i,
    input  logic              arr_req_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              sr_req_i,
    input  logic [7:0]        sr_data_i,
    output logic              arr_grant_o,
    output logic              arr_deny_o,
    output logic              sr_grant_o,
    output logic              sr_deny_o,
    output logic [7:0]        status_o
);
    logic busy_q;
    logic wr_done;
    logic wel;
    logic prot;
    logic lock;
    logic arr_ok;
    bp_e  bp;
    logic unused_bits;

    assign unused_bits = ^{sr_data_i[6:4], sr_data_i[1:0], arr_addr_i[ADDR_W-3:0]};
    assign wr_done     = busy_q && !busy_i;
    assign arr_ok      = wel && !busy_i && !prot;

    // Track busy to find the end of a write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_i;
    end

    // Registered array decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_grant_o <= 1'b0;
            arr_deny_o  <= 1'b0;
        end else begin
            arr_grant_o <= arr_req_i && arr_ok;
            arr_deny_o  <= arr_req_i && !arr_ok;
        end
    end

    wpc_latch i_latch (
        .clk(clk), .rst_n(rst_n), .set_i(set_wel_i), .clr_i(clr_wel_i),
        .busy_i(busy_i), .wr_done_i(wr_done), .wel_o(wel)
    );

    wpc_region i_region (
        .bp(bp), .addr_msb(arr_addr_i[ADDR_W-1 -: 2]), .prot(prot)
    );

    wpc_sreg i_sreg (
        .clk(clk), .rst_n(rst_n), .req_i(sr_req_i),
        .data_i({sr_data_i[7], sr_data_i[3:2]}), .wel_i(wel),
        .busy_i(busy_i), .wp_i(wp_i), .cs_n_i(cs_n_i), .bp_o(bp),
        .lock_o(lock), .grant_o(sr_grant_o), .deny_o(sr_deny_o)
    );

    assign status_o = {lock, 3'b000, bp, wel, busy_i};
endmodule

// File: rtl/wpc_ctrl_chk.sv
// Checker for the write protection controller, bound to the top.
module wpc_ctrl_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_i,
    input logic              wp_i,
    input logic              busy_i,
    input logic              set_wel_i,
    input logic              clr_wel_i,
    input logic              arr_req_i,
    input logic [ADDR_W-1:0] arr_addr_i,
    input logic              sr_req_i,
    input logic [7:0]        sr_data_i,
    input logic              arr_grant_o,
    input logic              arr_deny_o,
    input logic              sr_grant_o,
    input logic              sr_deny_o,
    input logic [7:0]        status_o
);
    // R4: a grant needs the latch set in the request cycle
    a_r4_grant_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        arr_grant_o |-> $past(status_o[1]));
    // R4: grant and deny never together
    a_r4_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_grant_o && arr_deny_o));
    // R6: no grant for a request made while busy
    a_r6_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_grant_o || sr_grant_o) |-> !$past(busy_i));
    // R3: end of write clears the latch
    a_r3_wel_clears_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_i) |=> !status_o[1]);
    // R9: commit never follows a sampled pin drop with lock armed and CS low
    a_r9_cancel_on_pin: assert property (@(posedge clk) disable iff (!rst_n)
        sr_grant_o |-> ($past(wp_i) || !$past(status_o[7]) || $past(cs_n_i)));
    // R8: stored bits change only with a commit
    a_r8_bits_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({status_o[7], status_o[3:2]}) |-> sr_grant_o);
    // R10: unused status bits read zero
    a_r10_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);
endmodule

bind wpc_ctrl wpc_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_wpc_ctrl.sv
module test_wpc_ctrl;
    localparam int AW = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wp = 1'b1, busy = 1'b0;
    logic set_wel = 1'b0, clr_wel = 1'b0, arr_req = 1'b0, sr_req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] sr_data = 8'h00;
    logic arr_grant, arr_deny, sr_grant, sr_deny;
    logic [7:0] status;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    bit m_wel, m_wpen, m_pend, m_bq, m_ag, m_ad, m_sg, m_sd;
    int m_bp, p_bp;
    bit p_wpen;

    always #2 clk = ~clk;

    wpc_ctrl #(.ADDR_W(AW)) i_wpc_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .wp_i(wp), .busy_i(busy),
        .set_wel_i(set_wel), .clr_wel_i(clr_wel), .arr_req_i(arr_req),
        .arr_addr_i(addr), .sr_req_i(sr_req), .sr_data_i(sr_data),
        .arr_grant_o(arr_grant), .arr_deny_o(arr_deny), .sr_grant_o(sr_grant),
        .sr_deny_o(sr_deny), .status_o(status)
    );

    function automatic bit is_prot(int bp, int a);
        if (bp == 1) return a >= 6144;
        if (bp == 2) return a >= 4096;
        return bp == 3;
    endfunction

    // behavioural reference, one step per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_wel = 0; m_wpen = 0; m_pend = 0; m_bq = 0; m_bp = 0;
            m_ag = 0; m_ad = 0; m_sg = 0; m_sd = 0;
        end else begin
            bit ok;
            ok = m_wel && !busy && !is_prot(m_bp, int'(addr));
            m_ag = arr_req && ok;
            m_ad = arr_req && !ok;
            m_sg = 0; m_sd = 0;
            if (sr_req) begin
                if (!m_wel || busy || (m_wpen && !wp)) m_sd = 1;
                else begin m_pend = 1; p_bp = int'(sr_data[3:2]); p_wpen = sr_data[7]; end
            end else if (m_pend) begin
                if (cs_n) begin m_sg = 1; m_bp = p_bp; m_wpen = p_wpen; m_pend = 0; end
                else if (m_wpen && !wp) begin m_sd = 1; m_pend = 0; end
            end
            if (clr_wel || (m_bq && !busy)) m_wel = 0;
            else if (set_wel && !busy) m_wel = 1;
            m_bq = busy;
        end
    end

    task automatic tick();
        logic [7:0] exp_st;
        @(negedge clk);
        exp_st = {m_wpen, 3'b000, 2'(m_bp), m_wel, busy};
        checks++;
        if (status !== exp_st || arr_grant !== m_ag || arr_deny !== m_ad ||
            sr_grant !== m_sg || sr_deny !== m_sd) begin
            fails++;
            $display("FAIL %s: status=%h ag=%b ad=%b sg=%b sd=%b expected status=%h ag=%b ad=%b sg=%b sd=%b",
                     tag, status, arr_grant, arr_deny, sr_grant, sr_deny,
                     exp_st, m_ag, m_ad, m_sg, m_sd);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            set_wel = 0; clr_wel = 0; arr_req = 0; sr_req = 0;
            tick();
        end
    endtask

    task automatic set_en();
        set_wel = 1; tick(); set_wel = 0; tick();
    endtask

    task automatic arr_wr(int a);
        addr = AW'(a); arr_req = 1; tick(); arr_req = 0; tick();
    endtask

    // status write: request, hold CS low, optional pin drop, then CS high
    task automatic sr_wr(logic [7:0] d, bit drop_pin);
        cs_n = 0; sr_data = d; sr_req = 1; tick(); sr_req = 0;
        if (drop_pin) wp = 0;
        tick();
        cs_n = 1; tick(); tick();
    endtask

    task automatic write_cycle();
        busy = 1; idle(3); busy = 0; idle(2);
    endtask

    initial begin
        tag = "R1";
        idle(3);
        rst_n = 1;
        idle(2);

        tag = "R4";
        arr_wr(0);
        set_en();
        arr_wr(0);

        tag = "R6";
        busy = 1; tick();
        arr_wr(16); sr_wr(8'h0C, 0);
        set_wel = 1; tick(); set_wel = 0;
        tag = "R3";
        busy = 0; idle(3);

        tag = "R2";
        set_en();
        clr_wel = 1; tick(); clr_wel = 0; tick();
        set_wel = 1; clr_wel = 1; tick(); set_wel = 0; clr_wel = 0; tick();

        tag = "R10";
        set_en();
        sr_wr(8'hFF, 0);
        tag = "R8";
        write_cycle();

        tag = "R5";
        set_en();
        arr_wr(0); arr_wr(8191);
        set_en();
        sr_wr(8'h84, 0);
        write_cycle();
        set_en();
        arr_wr(6143); arr_wr(6144); arr_wr(8191);
        tag = "R11";
        arr_wr(6144); idle(1);
        tag = "R5";
        sr_wr(8'h88, 0);
        write_cycle();
        set_en();
        arr_wr(4095); arr_wr(4096);

        tag = "R7";
        wp = 0;
        sr_wr(8'h80, 0);
        arr_wr(100);
        wp = 1;
        sr_wr(8'h08, 0);
        write_cycle();
        set_en();
        wp = 0;
        sr_wr(8'h84, 0);
        write_cycle();

        tag = "R9";
        wp = 1;
        set_en();
        sr_wr(8'h84, 0);
        write_cycle();
        set_en();
        sr_wr(8'h8C, 1);
        idle(2);
        wp = 1;
        sr_wr(8'h8C, 0);
        idle(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule